// File: doc/BRIEF.md
# Pattern-Flip Logic Lock Unit

This unit wraps a small combinational logic cone so that its output is trustworthy only after the right secret key has been loaded. The cone is an AND-OR tree. A flip stage compares the live cone inputs against a protected pattern that is fixed at build time. When they match, it inverts the cone result. A restore stage compares the same inputs against the key held in an on-chip register. When they match and the key is marked valid, it inverts the result again. The final output is the cone result XOR the flip signal XOR the restore signal. The correct key is therefore equal to the protected pattern.

The key never comes from the cone inputs. It is shifted in one bit per clock, most significant bit first, through a dedicated load port. A valid flag shows that a complete key is in place. Until that flag is high, the restore stage is disabled, so the unit gives a wrong answer for the protected pattern.

The serial load port has no back-pressure. Every cycle in which `key_shift_en` is high shifts in `key_bit`, and the upstream source never has to wait.

Top module: `pattern_lock`

## Requirements
- R1: For any input pattern that equals neither the protected pattern nor the held key while it is valid, `lock_y` equals the cone result in the same cycle.
- R2: While `key_ok` is low, the protected pattern gives `lock_y` equal to the inverse of the cone result.
- R3: With `key_ok` high and a held key equal to the protected pattern, `lock_y` equals the cone result for every input pattern.
- R4: With `key_ok` high and a held key different from the protected pattern, `lock_y` is the inverse of the cone result for exactly two inputs: the protected pattern and the held key.
- R5: After reset, the held key is all zeros and `key_ok` is low. As a result, even the all-zero input gets no restore.
- R6: The key register shifts left, taking `key_bit` into bit 0 on each enabled cycle. The first of the last W bits shifted in therefore becomes the MSB, and any earlier bits are discarded.
- R7: `key_ok` goes high one clock after the first cycle in which `key_shift_en` is sampled low, provided at least W bits were shifted in that burst. A burst of fewer than W bits leaves `key_ok` low.
- R8: Any cycle with `key_shift_en` high clears `key_ok` at that edge. While loading is in progress, the protected pattern is not restored.
- R9: The cone result is the OR, over i, of `cone_x[2i] & cone_x[2i+1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cone_x | input | W | Live inputs to the protected cone |
| key_shift_en | input | 1 | Shift `key_bit` into the key register this cycle |
| key_bit | input | 1 | Serial key data, MSB first |
| key_ok | output | 1 | A complete key is held and restore is enabled |
| lock_y | output | 1 | Locked cone output |

## Verification
`lock_y` is purely combinational from `cone_x` and the registered key state. The bench therefore drives `cone_x` on the falling edge and compares `lock_y` 1 ns later, in the same cycle. `key_ok` is a register: it changes at the rising edge that samples `key_shift_en`. It clears at the edge that takes a load bit, and it sets at the first edge that samples the port idle after W or more bits. The bench checks it at the falling edge that follows each of those rising edges.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int LOCK_W_DEF = 8;
  localparam logic [LOCK_W_DEF-1:0] LOCK_PATTERN_DEF = 8'hA5;
endpackage

// File: rtl/lock_cone.sv
module lock_cone #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  output logic         y
);
  localparam int PAIRS = W / 2;
  logic [PAIRS-1:0] terms;

  genvar gi;
  generate
    for (gi = 0; gi < PAIRS; gi++) begin : g_pair
      assign terms[gi] = x[2*gi] & x[2*gi+1];
    end
  endgenerate

  assign y = |terms;
endmodule

// File: rtl/lock_match.sv
module lock_match #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  assign hit = en && (a == b);
endmodule

// File: rtl/lock_key_loader.sv
module lock_key_loader #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] key_q,
  output logic         key_valid
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q     <= '0;
      cnt       <= '0;
      key_valid <= 1'b0;
    end else if (shift_en) begin
      key_q     <= {key_q[W-2:0], bit_in};
      key_valid <= 1'b0;
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end else begin
      if (cnt == FULL) key_valid <= 1'b1;
      cnt <= '0;
    end
  end

  AST_LOAD_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !key_valid); // R8
  AST_VALID_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_valid) |-> !$past(shift_en)); // R7
  AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(key_q)); // R6
endmodule

// File: rtl/pattern_lock.sv
module pattern_lock #(
  parameter int W = lock_pkg::LOCK_W_DEF,
  parameter logic [W-1:0] PROTECT = lock_pkg::LOCK_PATTERN_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cone_x,
  input  logic         key_shift_en,
  input  logic         key_bit,
  output logic         key_ok,
  output logic         lock_y
);
  logic         cone_y;
  logic         flip;
  logic         restore;
  logic [W-1:0] key_q;

  lock_cone #(.W(W)) u_cone (.x(cone_x), .y(cone_y));

  lock_key_loader #(.W(W)) u_loader (
    .clk(clk), .rst_n(rst_n), .shift_en(key_shift_en), .bit_in(key_bit),
    .key_q(key_q), .key_valid(key_ok)
  );

  lock_match #(.W(W)) u_flip (.en(1'b1), .a(cone_x), .b(PROTECT), .hit(flip));
  lock_match #(.W(W)) u_restore (.en(key_ok), .a(cone_x), .b(key_q), .hit(restore));

  assign lock_y = cone_y ^ flip ^ restore;

  AST_PASS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (cone_x != PROTECT && !(key_ok && cone_x == key_q)) |-> (lock_y == cone_y)); // R1
  AST_LOCKED_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_ok && cone_x == PROTECT) |-> (lock_y != cone_y)); // R2
  AST_RIGHT_KEY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ok && key_q == PROTECT) |-> (lock_y == cone_y)); // R3
endmodule

// File: tb/pattern_lock_test.sv
module pattern_lock_test;
  localparam int W = 8;
  localparam logic [W-1:0] PAT = 8'hA5;
  localparam logic [W-1:0] BAD = 8'h3C;

  logic clk = 0, rst_n = 0, key_shift_en = 0, key_bit = 0;
  logic [W-1:0] cone_x = '0;
  logic key_ok, lock_y;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pattern_lock #(.W(W), .PROTECT(PAT)) uut (
    .clk(clk), .rst_n(rst_n), .cone_x(cone_x), .key_shift_en(key_shift_en),
    .key_bit(key_bit), .key_ok(key_ok), .lock_y(lock_y));

  function automatic logic cone_ref(input logic [W-1:0] x);
    logic r = 0;
    for (int i = 0; i < W/2; i++) r = r | (x[2*i] & x[2*i+1]);
    return r;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic drive_x(input logic [W-1:0] v);
    @(negedge clk); cone_x = v; #1;
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); key_shift_en = 1; key_bit = bits[i];
    end
    @(negedge clk); key_shift_en = 0;
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic t_reset;
    drive_x(PAT);
    chk("R5 key_ok low", key_ok, 1'b0);
    chk("R2 locked pattern", lock_y, ~cone_ref(PAT));
    drive_x('0);
    chk("R5 zero input no restore", lock_y, cone_ref('0));
    drive_x(8'h03);
    chk("R9 pair0", lock_y, 1'b1);
    drive_x(8'h55);
    chk("R9 no pair", lock_y, 1'b0);
  endtask

  task automatic t_partial;
    shift_bits(16'h0015, 5);
    chk("R7 short burst", key_ok, 1'b0);
    drive_x(PAT);
    chk("R2 short burst pattern", lock_y, ~cone_ref(PAT));
  endtask

  task automatic t_right;
    shift_bits({8'h00, PAT}, W);
    chk("R7 full burst", key_ok, 1'b1);
    for (int v = 0; v < 256; v++) begin
      drive_x(v[W-1:0]);
      chk("R3 right key", lock_y, cone_ref(v[W-1:0]));
    end
  endtask

  task automatic t_reload_wrong;
    @(negedge clk); key_shift_en = 1; key_bit = BAD[W-1];
    @(posedge clk); #1;
    cone_x = PAT; #1;
    chk("R8 valid dropped", key_ok, 1'b0);
    chk("R8 no restore while loading", lock_y, ~cone_ref(PAT));
    for (int i = W - 2; i >= 0; i--) begin
      @(negedge clk); key_bit = BAD[i];
    end
    @(negedge clk); key_shift_en = 0;
    @(posedge clk); @(negedge clk); #1;
    chk("R7 wrong key valid", key_ok, 1'b1);
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] x = v[W-1:0];
      drive_x(x);
      chk((x == PAT || x == BAD) ? "R4 corrupted" : "R1 passes",
          lock_y, cone_ref(x) ^ (x == PAT) ^ (x == BAD));
    end
  endtask

  task automatic t_overlong;
    shift_bits({4'hF, 4'h6, PAT}, 16);
    chk("R6 overlong valid", key_ok, 1'b1);
    drive_x(PAT);
    chk("R6 last W bits kept", lock_y, cone_ref(PAT));
    drive_x(8'hF6);
    chk("R6 early bits gone", lock_y, cone_ref(8'hF6));
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset;
    t_partial;
    t_right;
    t_reload_wrong;
    t_overlong;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule